// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer that sits on a simple synchronous register bus. While it is enabled, a down-counter runs from a programmed load value. When the counter expires, the block flags a pending interrupt and reloads itself. If the reset output is enabled, it also drives a reset pulse whose length is programmable. Software must keep feeding the watchdog by writing the restart register. If it stops, the timeout and reset path takes over.

The load, control and restart registers accept writes only after a 32-bit key has been written to the lock register. Writing zero to the lock register closes them again. The block has two response modes:

- In single mode, every expiry can reset the system.
- In double mode, the first expiry only raises the interrupt. A reset follows only if that interrupt is still unacknowledged at the next expiry.

Software reads the running count through a request/done capture handshake. It acknowledges the interrupt by reading the end-of-interrupt register.

The bus uses plain strobes: `bus_wr` and `bus_rd` each last one cycle, and `bus_rdata` is combinational from `bus_addr`. There is no back-pressure, so every access completes in the cycle it is presented. Register word addresses: 0 load, 1 control, 2 restart, 3 capture, 4 count, 5 raw interrupt, 6 masked interrupt, 7 end-of-interrupt, 8 status, 9 lock.

Top module: `wdog_locked`

## Requirements
- R1: After reset, the load register reads 0xFFFFFF00, control reads 0x40, status reads 1, lock reads 0, and `irq` and `rst_out` are low.
- R2: Writing 0x5A5A5A5A to lock (address 9) opens the protected registers, and lock then reads 1. Writing 0x00000000 closes them, and lock reads 0. Any other value leaves the lock state unchanged. The lock register accepts writes at all times.
- R3: While the block is locked, writes to load, control and restart have no effect. Reads work at all times. Control bit 1 always reads 0.
- R4: Load bits 31:8 hold the count field F, and bits 7:0 read as 0. With control bit 0 (enable) set, the first expiry sets the pending interrupt at the clock edge 256·F+1 edges after the edge that wrote the enable.
- R5: Writing 1 to bit 0 of restart (address 2) reloads the counter. The next expiry then lands 256·F+1 edges after that write.
- R6: Raw interrupt (address 5) bit 0 shows the pending flag whatever the mask. Masked interrupt (address 6) bit 0 and `irq` show the pending flag only while control bit 6 (mask) is 0.
- R7: A read of end-of-interrupt (address 7) clears the pending flag. If an expiry falls in the same cycle as that read, the flag stays set.
- R8: In single mode (control bit 7 = 0) with control bit 2 set, each expiry drives `rst_out` high for exactly 2^(n+1) cycles, where n is control bits 5:3. The pulse starts at the expiry edge.
- R9: In double mode (control bit 7 = 1), an expiry with no pending interrupt only sets the interrupt. An expiry while the interrupt is still pending starts the reset pulse when control bit 2 is set.
- R10: With control bit 2 clear, `rst_out` never rises.
- R11: Writing 1 to bit 0 of capture (address 3) starts a snapshot. While the snapshot is in progress, status bit 0 reads 0 and capture bit 1 reads 0. One edge later, capture bit 1 reads 1 and count (address 4) holds the counter value that stood between the request edge and that edge.
- R12: A restart write that falls in the cycle the counter would expire wins. No interrupt is raised, and the counter reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; qualifies read side effects |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked interrupt |
| rst_out | output | 1 | System reset pulse, active high |

## Verification
Two kinds of event can land on the same clock edge as counter expiry: an end-of-interrupt read and a restart write. The bench counts edges from the enabling write and places each access exactly on the expiry edge. After the collision it judges the result at the pins:

- For the end-of-interrupt read, `irq` must stay high after the colliding read and fall only after a second read.
- For the restart write, `irq` must stay low and the next expiry must arrive one full period later.

// File: rtl/wdl_pkg.sv
package wdl_pkg;
  localparam int PLEN_W = 3;

  typedef enum logic [3:0] {
    A_LOAD    = 4'd0,
    A_CTRL    = 4'd1,
    A_RESTART = 4'd2,
    A_SNAP    = 4'd3,
    A_COUNT   = 4'd4,
    A_RAW     = 4'd5,
    A_MASKED  = 4'd6,
    A_EOI     = 4'd7,
    A_STATUS  = 4'd8,
    A_LOCK    = 4'd9
  } wdl_addr_e;

  typedef struct packed {
    logic              dbl;
    logic              mask;
    logic [PLEN_W-1:0] plen;
    logic              rst_en;
    logic              en;
  } wdl_ctrl_t;
endpackage

// File: rtl/wdl_regs.sv
module wdl_regs
  import wdl_pkg::*;
#(
  parameter int          FIELD_W = 24,
  parameter int          RSV_W   = 8,
  parameter logic [31:0] KEY     = 32'h5A5A5A5A,
  localparam int         DATA_W  = FIELD_W + RSV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cnt,
  input  logic              pend,
  output wdl_ctrl_t         ctrl,
  output logic [DATA_W-1:0] reload,
  output logic              restart,
  output logic              eoi,
  output logic              unlocked
);
  logic [FIELD_W-1:0] field_q;
  wdl_ctrl_t          ctrl_q;
  logic               open_q;
  logic               req_q;
  logic               done_q;
  logic [DATA_W-1:0]  snap_q;
  wdl_addr_e          addr;
  logic               wr_cfg;

  assign addr   = wdl_addr_e'(bus_addr);
  assign wr_cfg = bus_wr && open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q <= '1;
      ctrl_q  <= '{dbl: 1'b0, mask: 1'b1, plen: '0, rst_en: 1'b0, en: 1'b0};
      open_q  <= 1'b0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      snap_q  <= '0;
    end else begin
      if (bus_wr && addr == A_LOCK) begin
        if (bus_wdata == KEY) open_q <= 1'b1;
        else if (bus_wdata == '0) open_q <= 1'b0;
      end
      if (wr_cfg && addr == A_LOAD) field_q <= bus_wdata[DATA_W-1:RSV_W];
      if (wr_cfg && addr == A_CTRL)
        ctrl_q <= '{dbl: bus_wdata[7], mask: bus_wdata[6], plen: bus_wdata[5:3],
                    rst_en: bus_wdata[2], en: bus_wdata[0]};
      if (req_q) begin
        snap_q <= cnt;
        done_q <= 1'b1;
        req_q  <= 1'b0;
      end
      if (bus_wr && addr == A_SNAP && bus_wdata[0]) begin
        req_q  <= 1'b1;
        done_q <= 1'b0;
      end
    end
  end

  assign ctrl     = ctrl_q;
  assign reload   = {field_q, {RSV_W{1'b0}}};
  assign restart  = wr_cfg && addr == A_RESTART && bus_wdata[0];
  assign eoi      = bus_rd && addr == A_EOI;
  assign unlocked = open_q;

  always_comb begin
    bus_rdata = '0;
    case (addr)
      A_LOAD:   bus_rdata = reload;
      A_CTRL:   bus_rdata[7:0] = {ctrl_q.dbl, ctrl_q.mask, ctrl_q.plen, ctrl_q.rst_en, 1'b0, ctrl_q.en};
      A_SNAP:   bus_rdata[1:0] = {done_q, req_q};
      A_COUNT:  bus_rdata = snap_q;
      A_RAW:    bus_rdata[0] = pend;
      A_MASKED: bus_rdata[0] = pend && !ctrl_q.mask;
      A_STATUS: bus_rdata[0] = !req_q;
      A_LOCK:   bus_rdata[0] = open_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdl_count.sv
module wdl_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         tmo
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!en || restart)     cnt_q <= reload;
    else if (cnt_q == '0)        cnt_q <= reload;
    else                         cnt_q <= cnt_q - 1'b1;
  end

  assign cnt = cnt_q;
  assign tmo = en && !restart && (cnt_q == '0);
endmodule

// File: rtl/wdl_resp.sv
module wdl_resp #(
  parameter int PLEN_W = 3,
  localparam int LEN_W = (1 << PLEN_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo,
  input  logic              eoi,
  input  logic              dbl,
  input  logic              rst_en,
  input  logic [PLEN_W-1:0] plen,
  output logic              pend,
  output logic              rst_out
);
  logic             pend_q;
  logic [LEN_W-1:0] left_q;
  logic             fire;

  assign fire = tmo && rst_en && (!dbl || pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      left_q <= '0;
    end else begin
      if (tmo)      pend_q <= 1'b1;
      else if (eoi) pend_q <= 1'b0;
      if (fire)                left_q <= LEN_W'(1) << ({1'b0, plen} + 1'b1);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
    end
  end

  assign pend    = pend_q;
  assign rst_out = (left_q != '0);
endmodule

// File: rtl/wdog_locked.sv
module wdog_locked
  import wdl_pkg::*;
#(
  parameter int          FIELD_W = 24,
  parameter int          RSV_W   = 8,
  parameter logic [31:0] KEY     = 32'h5A5A5A5A,
  localparam int         DATA_W  = FIELD_W + RSV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_out
);
  wdl_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] reload;
  logic [DATA_W-1:0] cnt;
  logic              restart;
  logic              eoi;
  logic              unlocked;
  logic              tmo;
  logic              pend;

  wdl_regs #(.FIELD_W(FIELD_W), .RSV_W(RSV_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .pend(pend), .ctrl(ctrl_q), .reload(reload),
    .restart(restart), .eoi(eoi), .unlocked(unlocked)
  );

  wdl_count #(.W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .restart(restart),
    .reload(reload), .cnt(cnt), .tmo(tmo)
  );

  wdl_resp #(.PLEN_W(PLEN_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .tmo(tmo), .eoi(eoi), .dbl(ctrl_q.dbl),
    .rst_en(ctrl_q.rst_en), .plen(ctrl_q.plen), .pend(pend), .rst_out(rst_out)
  );

  assign irq = pend && !ctrl_q.mask;
endmodule

// File: rtl/wdl_chk.sv
module wdl_chk
  import wdl_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input wdl_ctrl_t ctrl,
  input logic      unlocked,
  input logic      tmo,
  input logic      pend,
  input logic      eoi,
  input logic      restart,
  input logic      rst_out
);
  // R3
  locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(ctrl));
  // R7
  tmo_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> pend);
  // R7
  eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !tmo) |=> !pend);
  // R8
  rst_from_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(tmo));
  // R9
  dbl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && ctrl.dbl && !pend && !rst_out) |=> !rst_out);
  // R10
  no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.rst_en && !rst_out) |=> !rst_out);
  // R12
  restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !pend) |=> !pend);
endmodule

bind wdog_locked wdl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .unlocked(unlocked), .tmo(tmo),
  .pend(pend), .eoi(eoi), .restart(restart), .rst_out(rst_out)
);

// File: tb/wdog_locked_test.sv
module wdog_locked_test;
  localparam logic [3:0] LOAD = 4'd0, CTRL = 4'd1, RESTART = 4'd2, SNAP = 4'd3,
                         COUNT = 4'd4, RAW = 4'd5, MASKED = 4'd6, EOI = 4'd7,
                         STATUS = 4'd8, LOCK = 4'd9;
  localparam logic [31:0] KEYV = 32'h5A5A5A5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        rst_out;
  int          n_vec = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  wdog_locked uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_out(rst_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] v;
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    check(req, v, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
  endtask

  // ctrl written at edge E; load field 1 so the period is 256+1 edges
  task automatic arm(logic [31:0] ctl);
    do_reset(); wr(LOCK, KEYV); wr(LOAD, 32'h100); wr(CTRL, ctl);
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk("R1", LOAD, 32'hFFFFFF00);
    rd_chk("R1", CTRL, 32'h40);
    rd_chk("R1", STATUS, 32'h1);
    rd_chk("R1", LOCK, 32'h0);
    check("R1 irq", irq, 0);
    check("R1 rst_out", rst_out, 0);
  endtask

  task automatic t_lock();
    do_reset();
    wr(CTRL, 32'h1);            rd_chk("R3 ctrl locked", CTRL, 32'h40);
    wr(LOCK, 32'h12345678);     rd_chk("R2 bad key", LOCK, 32'h0);
    wr(LOCK, KEYV);             rd_chk("R2 key", LOCK, 32'h1);
    wr(LOAD, 32'h1FF);          rd_chk("R4 low bits", LOAD, 32'h100);
    wr(CTRL, 32'h0FF);          rd_chk("R3 bit1", CTRL, 32'hFD);
    wr(LOCK, 32'h0);            rd_chk("R2 relock", LOCK, 32'h0);
    wr(LOAD, 32'h300);          rd_chk("R3 load locked", LOAD, 32'h100);
    wr(CTRL, 32'h0);            rd_chk("R3 ctrl locked", CTRL, 32'hFD);
  endtask

  task automatic t_timeout();
    arm(32'h01);
    tick(256); check("R4 early", irq, 0);
    tick(1);   check("R4 expiry", irq, 1);
    rd_chk("R6 raw", RAW, 1);
    rd_chk("R6 masked", MASKED, 1);
  endtask

  task automatic t_mask();
    arm(32'h41);
    tick(257); check("R6 masked irq", irq, 0);
    rd_chk("R6 raw", RAW, 1);
    rd_chk("R6 masked reg", MASKED, 0);
    wr(CTRL, 32'h01); check("R6 unmask", irq, 1);
  endtask

  task automatic t_restart();
    arm(32'h01);
    tick(200); wr(RESTART, 1);
    tick(256); check("R5 no early expiry", irq, 0);
    tick(1);   check("R5 expiry after feed", irq, 1);
    // locked feed ignored
    arm(32'h01);
    wr(LOCK, 0); tick(100); wr(RESTART, 1);
    tick(154); check("R3 before expiry", irq, 0);
    tick(1);   check("R3 feed ignored", irq, 1);
  endtask

  task automatic t_collide();
    arm(32'h01);
    tick(256); wr(RESTART, 1);
    check("R12 restart wins", irq, 0);
    tick(256); check("R12 reloaded", irq, 0);
    tick(1);   check("R12 next expiry", irq, 1);
    arm(32'h01);
    tick(256); rd_chk("R7 eoi on expiry", EOI, 0);
    check("R7 expiry wins", irq, 1);
    rd_chk("R7 eoi", EOI, 0);
    check("R7 cleared", irq, 0);
    rd_chk("R7 raw cleared", RAW, 0);
  endtask

  task automatic pulse_len(string req, logic [31:0] ctl, int exp);
    int n;
    arm(ctl);
    tick(256); check(req, rst_out, 0);
    n = 0; tick(1);
    while (rst_out && n < 400) begin n++; tick(1); end
    check(req, n, exp);
  endtask

  task automatic t_single();
    pulse_len("R8 code2", 32'h15, 8);
    pulse_len("R8 code7", 32'h3D, 256);
    pulse_len("R8 code0", 32'h05, 2);
  endtask

  task automatic t_double();
    arm(32'h85);
    tick(257); check("R9 first irq", irq, 1);
    check("R9 first no rst", rst_out, 0);
    tick(257); check("R9 second rst", rst_out, 1);
    arm(32'h85);
    tick(257); rd_chk("R9 eoi", EOI, 0);
    tick(256); check("R9 cleared no rst", rst_out, 0);
    check("R9 irq again", irq, 1);
  endtask

  task automatic t_norst();
    int hits;
    arm(32'h39);
    hits = 0;
    for (int i = 0; i < 600; i++) begin tick(1); if (rst_out) hits++; end
    check("R10 no reset", hits, 0);
    check("R10 irq", irq, 1);
  endtask

  task automatic t_snap();
    arm(32'h01);
    wr(SNAP, 1);
    rd_chk("R11 busy", STATUS, 0);
    rd_chk("R11 done", SNAP, 32'h2);
    rd_chk("R11 value", COUNT, 32'd255);
    rd_chk("R11 idle", STATUS, 1);
  endtask

  initial begin
    tick(1);
    t_reset(); t_lock(); t_timeout(); t_mask(); t_restart();
    t_collide(); t_single(); t_double(); t_norst(); t_snap();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule